// File: doc/BRIEF.md
# Processor Interrupt Entry Sequencer

This block is the part of a small 8-bit processor core that chooses, at every instruction boundary, between fetching the next opcode and running an interrupt entry. Hardware requests come in on two lines. One is a maskable request sampled as a level. The other is a non-maskable request detected on its rising edge. A fetched break opcode (0x00) starts the same entry as a software interrupt. The block keeps the program counter, the 8-bit stack pointer and the status register. It drives a byte-wide memory bus with a combinational read path.

An entry always takes seven cycles. It saves the return address and the status byte on the stack in page 0x01 and then loads the program counter from a little-endian vector. The source of the entry decides three things: which return address is saved, whether the break bit is set in the saved status byte, and which vector is read. After reset the block reads the reset vector before the first boundary. The rest of the core reports instruction boundaries on `insn_end`, takes the fetched opcode from `opc` and `opc_valid`, and may load the status register while the sequencer is idle.

Top module: `intr_entry_seq`

## Requirements
- R1: After reset the program counter holds the little-endian word at 0xFFFC (low) and 0xFFFD (high). The status reads 0x24 (interrupt-disable bit 2 set, bit 5 set). The stack pointer is 0xFD. Any interrupt request recorded before reset is discarded.
- R2: At a boundary with nothing pending and an opcode other than 0x00 at the program counter, the block reads that address and presents the opcode with `opc_valid` high in the same cycle. The program counter then advances by one. Bus read and bus write are never active together.
- R3: The maskable request is recorded only in cycles where status bit 2 is clear. Holding it high while bit 2 is set causes no entry.
- R4: The non-maskable request is recorded on a rising edge whatever the value of bit 2. A level held high starts only one entry.
- R5: A hardware entry lasts seven cycles, counted from the boundary cycle. It writes the high byte and then the low byte of the address of the opcode that was not fetched, followed by the status byte. The writes go to 0x0100+SP, and SP drops by one after each write, three in total.
- R6: Fetching opcode 0x00 at a boundary starts a software break. The saved return address is the address of the break opcode plus two.
- R7: The saved status byte equals the status register with bit 5 set. Bit 4 (break) is set only for a software break.
- R8: After an entry, status bit 2 is set and bit 3 (decimal) is unchanged.
- R9: A non-maskable entry loads the program counter from 0xFFFA (low) and 0xFFFB (high). Maskable and break entries load it from 0xFFFE (low) and 0xFFFF (high).
- R10: When both requests are recorded at the same boundary, the non-maskable one is served first. The maskable record survives and is served at the next boundary, even though bit 2 is now set.
- R11: The record of the source being served is cleared in the cycle the vector is loaded.
- R12: A status load takes effect only in an idle cycle without a boundary. Bit 4 always reads 0 and bit 5 reads 1. A load presented during an entry is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| nmi_in | input | 1 | Non-maskable request, edge sensitive |
| irq_in | input | 1 | Maskable request, level sensitive |
| insn_end | input | 1 | Instruction boundary reached in this cycle |
| sr_load | input | 1 | Load the status register from `sr_load_val` |
| sr_load_val | input | 8 | Status value to load |
| bus_rdata | input | 8 | Read data from memory, same cycle |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Bus read strobe |
| bus_wr | output | 1 | Bus write strobe |
| bus_wdata | output | 8 | Bus write data |
| opc_valid | output | 1 | An opcode was fetched in this cycle |
| opc | output | 8 | Fetched opcode |
| entry_active | output | 1 | Entry sequence in progress after its boundary cycle |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |
| sr | output | 8 | Status register |

## Verification
The hardest case to reach is a maskable record that is still held after a non-maskable entry has set the disable bit, so that an entry happens while masking is active. The bench gets there by clearing the disable bit, raising the maskable line, pulsing the non-maskable line, and dropping the maskable line, all before the boundary. The first entry then goes to the non-maskable vector, and the next boundary must still enter through the maskable vector. A sweep over the three entry sources, several status values and several program counter positions also holds the status load high during one of the entries, to show that the load is ignored while an entry runs.

// File: rtl/ies_pkg.sv
package ies_pkg;

  typedef enum logic [3:0] {
    S_RST_LO,
    S_RST_HI,
    S_IDLE,
    S_PAD,
    S_PUSH_H,
    S_PUSH_L,
    S_PUSH_S,
    S_VEC_L,
    S_VEC_H
  } seq_state_e;

  typedef enum logic [1:0] {
    SRC_IRQ,
    SRC_NMI,
    SRC_BRK
  } entry_src_e;

  // status bit positions
  localparam int unsigned SR_I = 2;
  localparam int unsigned SR_D = 3;
  localparam int unsigned SR_B = 4;
  localparam int unsigned SR_U = 5;

endpackage

// File: rtl/ies_pending.sv
module ies_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic irq_in,
  input  logic irq_mask,
  input  logic clr_nmi,
  input  logic clr_irq,
  output logic nmi_pend,
  output logic irq_pend
);

  logic nmi_q, nmi_pend_q, irq_pend_q;
  logic nmi_pend_d, irq_pend_d, nmi_edge;

  always_comb begin
    nmi_edge   = nmi_in & ~nmi_q;
    // a new edge wins over a clear in the same cycle
    nmi_pend_d = nmi_edge | (nmi_pend_q & ~clr_nmi);
    irq_pend_d = (irq_in & ~irq_mask) | (irq_pend_q & ~clr_irq);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q      <= 1'b0;
      nmi_pend_q <= 1'b0;
      irq_pend_q <= 1'b0;
    end else begin
      nmi_q      <= nmi_in;
      nmi_pend_q <= nmi_pend_d;
      irq_pend_q <= irq_pend_d;
    end
  end

  assign nmi_pend = nmi_pend_q;
  assign irq_pend = irq_pend_q;

endmodule

// File: rtl/ies_status.sv
module ies_status
  import ies_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [DW-1:0] load_val,
  input  logic          set_mask,
  output logic [DW-1:0] sr
);

  localparam logic [DW-1:0] BIT_I = DW'(1) << SR_I;
  localparam logic [DW-1:0] BIT_B = DW'(1) << SR_B;
  localparam logic [DW-1:0] BIT_U = DW'(1) << SR_U;
  localparam logic [DW-1:0] SR_RESET = BIT_I | BIT_U;

  logic [DW-1:0] sr_q, sr_d;
  logic          sr_en;

  always_comb begin
    sr_en = set_mask | load_en;
    sr_d  = sr_q;
    if (set_mask)
      sr_d = sr_q | BIT_I;
    else if (load_en)
      sr_d = (load_val & ~BIT_B) | BIT_U;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sr_q <= SR_RESET;
    else if (sr_en)
      sr_q <= sr_d;
  end

  assign sr = sr_q;

endmodule

// File: rtl/ies_stack.sv
module ies_stack #(
  parameter int            DW         = 8,
  parameter logic [DW-1:0] SP_INIT    = 8'hFD,
  parameter logic [DW-1:0] STACK_PAGE = 8'h01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  output logic [DW-1:0]   sp,
  output logic [2*DW-1:0] push_addr
);

  logic [DW-1:0] sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sp_q <= SP_INIT;
    else if (push)
      sp_q <= sp_q - DW'(1);
  end

  assign sp        = sp_q;
  assign push_addr = {STACK_PAGE, sp_q};

endmodule

// File: rtl/ies_seq.sv
module ies_seq
  import ies_pkg::*;
#(
  parameter int              DW         = 8,
  parameter int              AW         = 16,
  parameter logic [DW-1:0]   BRK_OPCODE = 8'h00,
  parameter logic [AW-1:0]   VEC_NMI    = 16'hFFFA,
  parameter logic [AW-1:0]   VEC_RST    = 16'hFFFC,
  parameter logic [AW-1:0]   VEC_IRQ    = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_end,
  input  logic          nmi_pend,
  input  logic          irq_pend,
  input  logic [DW-1:0] sr,
  input  logic [AW-1:0] stack_addr,
  input  logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  output logic          opc_valid,
  output logic [DW-1:0] opc,
  output logic          push,
  output logic          set_mask,
  output logic          clr_nmi,
  output logic          clr_irq,
  output logic          entry_active,
  output logic          load_ok,
  output logic [AW-1:0] pc
);

  localparam logic [DW-1:0] BIT_B = DW'(1) << SR_B;

  seq_state_e    state_q, state_d;
  entry_src_e    src_q, src_d;
  logic [AW-1:0] pc_q, pc_d;
  logic [DW-1:0] vlo_q, vlo_d;
  logic [AW-1:0] vec_base;

  assign vec_base = (src_q == SRC_NMI) ? VEC_NMI : VEC_IRQ;

  always_comb begin
    state_d   = state_q;
    src_d     = src_q;
    pc_d      = pc_q;
    vlo_d     = vlo_q;
    bus_addr  = pc_q;
    bus_rd    = 1'b0;
    bus_wr    = 1'b0;
    bus_wdata = '0;
    opc_valid = 1'b0;
    push      = 1'b0;
    set_mask  = 1'b0;
    clr_nmi   = 1'b0;
    clr_irq   = 1'b0;
    unique case (state_q)
      S_RST_LO: begin
        bus_rd   = 1'b1;
        bus_addr = VEC_RST;
        vlo_d    = bus_rdata;
        state_d  = S_RST_HI;
      end
      S_RST_HI: begin
        bus_rd   = 1'b1;
        bus_addr = VEC_RST + AW'(1);
        pc_d     = {bus_rdata, vlo_q};
        state_d  = S_IDLE;
      end
      S_IDLE: begin
        if (insn_end) begin
          bus_rd = 1'b1;
          if (nmi_pend) begin
            src_d   = SRC_NMI;
            state_d = S_PAD;
          end else if (irq_pend) begin
            src_d   = SRC_IRQ;
            state_d = S_PAD;
          end else if (bus_rdata == BRK_OPCODE) begin
            src_d   = SRC_BRK;
            pc_d    = pc_q + AW'(1);
            state_d = S_PAD;
          end else begin
            opc_valid = 1'b1;
            pc_d      = pc_q + AW'(1);
          end
        end
      end
      S_PAD: begin
        bus_rd  = 1'b1;
        if (src_q == SRC_BRK)
          pc_d = pc_q + AW'(1);
        state_d = S_PUSH_H;
      end
      S_PUSH_H: begin
        bus_wr    = 1'b1;
        bus_addr  = stack_addr;
        bus_wdata = pc_q[AW-1:DW];
        push      = 1'b1;
        state_d   = S_PUSH_L;
      end
      S_PUSH_L: begin
        bus_wr    = 1'b1;
        bus_addr  = stack_addr;
        bus_wdata = pc_q[DW-1:0];
        push      = 1'b1;
        state_d   = S_PUSH_S;
      end
      S_PUSH_S: begin
        bus_wr    = 1'b1;
        bus_addr  = stack_addr;
        bus_wdata = (src_q == SRC_BRK) ? (sr | BIT_B) : sr;
        push      = 1'b1;
        set_mask  = 1'b1;
        state_d   = S_VEC_L;
      end
      S_VEC_L: begin
        bus_rd   = 1'b1;
        bus_addr = vec_base;
        vlo_d    = bus_rdata;
        state_d  = S_VEC_H;
      end
      S_VEC_H: begin
        bus_rd   = 1'b1;
        bus_addr = vec_base + AW'(1);
        pc_d     = {bus_rdata, vlo_q};
        clr_nmi  = (src_q == SRC_NMI);
        clr_irq  = (src_q == SRC_IRQ);
        state_d  = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_RST_LO;
      src_q   <= SRC_IRQ;
      pc_q    <= '0;
      vlo_q   <= '0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      pc_q    <= pc_d;
      vlo_q   <= vlo_d;
    end
  end

  assign opc          = bus_rdata;
  assign entry_active = (state_q != S_IDLE) && (state_q != S_RST_LO) && (state_q != S_RST_HI);
  assign load_ok      = (state_q == S_IDLE) && !insn_end;
  assign pc           = pc_q;

endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
  import ies_pkg::*;
#(
  parameter int                DW         = 8,
  parameter logic [DW-1:0]     BRK_OPCODE = 8'h00,
  parameter logic [DW-1:0]     SP_INIT    = 8'hFD,
  parameter logic [DW-1:0]     STACK_PAGE = 8'h01,
  parameter logic [2*DW-1:0]   VEC_NMI    = 16'hFFFA,
  parameter logic [2*DW-1:0]   VEC_RST    = 16'hFFFC,
  parameter logic [2*DW-1:0]   VEC_IRQ    = 16'hFFFE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_in,
  input  logic             irq_in,
  input  logic             insn_end,
  input  logic             sr_load,
  input  logic [DW-1:0]    sr_load_val,
  input  logic [DW-1:0]    bus_rdata,
  output logic [2*DW-1:0]  bus_addr,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic [DW-1:0]    bus_wdata,
  output logic             opc_valid,
  output logic [DW-1:0]    opc,
  output logic             entry_active,
  output logic [2*DW-1:0]  pc,
  output logic [DW-1:0]    sp,
  output logic [DW-1:0]    sr
);

  localparam int AW = 2 * DW;

  logic [1:0]    rst_sync_q;
  logic          rst_core_n;
  logic          nmi_pend, irq_pend;
  logic          push, set_mask, clr_nmi, clr_irq, load_ok;
  logic [AW-1:0] stack_addr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  ies_pending u_pend (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .nmi_in   (nmi_in),
    .irq_in   (irq_in),
    .irq_mask (sr[SR_I]),
    .clr_nmi  (clr_nmi),
    .clr_irq  (clr_irq),
    .nmi_pend (nmi_pend),
    .irq_pend (irq_pend)
  );

  ies_status #(.DW(DW)) u_sr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load_en  (sr_load & load_ok),
    .load_val (sr_load_val),
    .set_mask (set_mask),
    .sr       (sr)
  );

  ies_stack #(.DW(DW), .SP_INIT(SP_INIT), .STACK_PAGE(STACK_PAGE)) u_stk (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .push      (push),
    .sp        (sp),
    .push_addr (stack_addr)
  );

  ies_seq #(
    .DW(DW), .AW(AW), .BRK_OPCODE(BRK_OPCODE),
    .VEC_NMI(VEC_NMI), .VEC_RST(VEC_RST), .VEC_IRQ(VEC_IRQ)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .insn_end     (insn_end),
    .nmi_pend     (nmi_pend),
    .irq_pend     (irq_pend),
    .sr           (sr),
    .stack_addr   (stack_addr),
    .bus_rdata    (bus_rdata),
    .bus_addr     (bus_addr),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .opc_valid    (opc_valid),
    .opc          (opc),
    .push         (push),
    .set_mask     (set_mask),
    .clr_nmi      (clr_nmi),
    .clr_irq      (clr_irq),
    .entry_active (entry_active),
    .load_ok      (load_ok),
    .pc           (pc)
  );

endmodule

// File: rtl/ies_checker.sv
module ies_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] bus_addr,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [7:0]  bus_wdata,
  input logic        opc_valid,
  input logic        entry_active,
  input logic [15:0] pc,
  input logic [7:0]  sp,
  input logic [7:0]  sr
);

  // R2: read and write never overlap
  p_rd_wr_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  // R2: a fetch advances the program counter by one
  p_fetch_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    opc_valid |=> pc == $past(pc) + 16'd1);

  // R2: no opcode is handed out while an entry runs
  p_no_fetch_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    opc_valid |-> !entry_active);

  // R5: every write lands in the stack page
  p_stack_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> bus_addr[15:8] == 8'h01);

  // R5: the pointer drops by one per write
  p_sp_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> sp == $past(sp) - 8'd1);

  // R5: writes come as a run of exactly three
  p_three_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr) |=> bus_wr ##1 bus_wr ##1 !bus_wr);

  // R7: the saved status byte has bit 5 set
  p_push_u_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && $past(bus_wr) && $past(bus_wr, 2)) |-> bus_wdata[5]);

  // R8: masking is on once an entry ends
  p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(entry_active) |-> sr[2]);

  // R8: decimal bit untouched during an entry
  p_dec_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    entry_active |=> $stable(sr[3]));

endmodule

bind intr_entry_seq ies_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .bus_addr     (bus_addr),
  .bus_rd       (bus_rd),
  .bus_wr       (bus_wr),
  .bus_wdata    (bus_wdata),
  .opc_valid    (opc_valid),
  .entry_active (entry_active),
  .pc           (pc),
  .sp           (sp),
  .sr           (sr)
);

// File: tb/tb_intr_entry_seq.sv
module tb_intr_entry_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        nmi_in, irq_in, insn_end, sr_load;
  logic [7:0]  sr_load_val, bus_rdata, bus_wdata, opc, sp, sr;
  logic [15:0] bus_addr, pc;
  logic        bus_rd, bus_wr, opc_valid, entry_active;

  int nchk = 0;
  int nerr = 0;
  int nw   = 0;
  logic [15:0] exp_pc;

  logic [7:0]  mem [0:4095];
  logic [15:0] wa  [0:63];
  logic [7:0]  wd  [0:63];

  always #10 clk = ~clk;

  intr_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .irq_in(irq_in),
    .insn_end(insn_end), .sr_load(sr_load), .sr_load_val(sr_load_val),
    .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .opc_valid(opc_valid),
    .opc(opc), .entry_active(entry_active), .pc(pc), .sp(sp), .sr(sr)
  );

  // memory model: 4 KiB aliased over the 64 KiB space
  assign bus_rdata = mem[bus_addr[11:0]];

  always @(posedge clk) begin
    if (bus_wr) begin
      mem[bus_addr[11:0]] <= bus_wdata;
      wa[nw & 63] <= bus_addr;
      wd[nw & 63] <= bus_wdata;
      nw <= nw + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; nmi_in = 0; irq_in = 0; insn_end = 0;
    sr_load = 0; sr_load_val = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    exp_pc = 16'h0200;
  endtask

  task automatic fetch(input string req);
    logic [7:0] want;
    @(negedge clk);
    want = mem[exp_pc[11:0]];
    insn_end = 1'b1;
    #2;
    chk({req, " opc_valid"}, int'(opc_valid), 1);
    chk({req, " opcode"}, int'(opc), int'(want));
    @(negedge clk);
    insn_end = 1'b0;
    exp_pc = exp_pc + 16'd1;
    chk({req, " pc advance"}, int'(pc), int'(exp_pc));
  endtask

  task automatic load_sr(input logic [7:0] v);
    @(negedge clk);
    sr_load = 1'b1; sr_load_val = v;
    @(negedge clk);
    sr_load = 1'b0;
    chk("R12 status load", int'(sr), int'((v & 8'hEF) | 8'h20));
  endtask

  // kind: 0 maskable, 1 non-maskable, 2 break
  task automatic entry(input int kind, input logic [15:0] ret,
                       input logic [7:0] st_exp, input bit load_during);
    int base;
    logic [7:0]  sp0, sr0;
    logic [15:0] vec;
    vec  = (kind == 1) ? 16'h0300 : 16'h0400;
    base = nw;
    sp0  = sp;
    sr0  = sr;
    @(negedge clk);
    insn_end = 1'b1;
    #2;
    chk("R2 no opcode at entry boundary", int'(opc_valid), 0);
    @(negedge clk);
    insn_end = 1'b0;
    if (load_during) begin sr_load = 1'b1; sr_load_val = 8'h00; end
    chk("R5 entry active", int'(entry_active), 1);
    repeat (6) @(negedge clk);
    sr_load = 1'b0;
    chk("R5 entry done after 7 cycles", int'(entry_active), 0);
    chk("R9 vector loaded", int'(pc), int'(vec));
    chk("R5 sp net -3", int'(sp), int'(sp0 - 8'd3));
    chk("R5 write count", nw - base, 3);
    chk("R5 push hi addr", int'(wa[base & 63]), int'({8'h01, sp0}));
    chk("R5 push lo addr", int'(wa[(base + 1) & 63]), int'({8'h01, sp0 - 8'd1}));
    chk("R5 push st addr", int'(wa[(base + 2) & 63]), int'({8'h01, sp0 - 8'd2}));
    chk(kind == 2 ? "R6 return hi" : "R5 return hi", int'(wd[base & 63]), int'(ret[15:8]));
    chk(kind == 2 ? "R6 return lo" : "R5 return lo", int'(wd[(base + 1) & 63]), int'(ret[7:0]));
    chk("R7 saved status", int'(wd[(base + 2) & 63]), int'(st_exp));
    chk("R8 mask set", int'(sr[2]), 1);
    chk("R8 decimal kept", int'(sr[3]), int'(sr0[3]));
    if (load_during) chk("R12 load ignored in entry", int'(sr & 8'hFB), int'(sr0 & 8'hFB));
    exp_pc = vec;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'hEA;
    mem[12'hFFA] = 8'h00; mem[12'hFFB] = 8'h03;
    mem[12'hFFC] = 8'h00; mem[12'hFFD] = 8'h02;
    mem[12'hFFE] = 8'h00; mem[12'hFFF] = 8'h04;

    // R1: reset state
    do_reset();
    chk("R1 pc from reset vector", int'(pc), 16'h0200);
    chk("R1 status", int'(sr), 8'h24);
    chk("R1 sp", int'(sp), 8'hFD);
    chk("R1 idle", int'(entry_active), 0);
    // R1: a recorded edge is dropped by reset
    @(negedge clk); nmi_in = 1'b1;
    @(negedge clk); nmi_in = 1'b0;
    do_reset();
    fetch("R1 pending dropped by reset");

    // R3: masked level is not recorded, then recorded once unmasked
    do_reset();
    irq_in = 1'b1;
    repeat (3) @(negedge clk);
    fetch("R3 masked request ignored");
    load_sr(8'h00);
    @(negedge clk);
    entry(0, exp_pc, 8'h20, 1'b0);
    irq_in = 1'b0;
    fetch("R11 maskable record cleared");

    // R10: both recorded; non-maskable first, maskable record survives
    do_reset();
    load_sr(8'h00);
    @(negedge clk); irq_in = 1'b1; nmi_in = 1'b1;
    @(negedge clk); irq_in = 1'b0; nmi_in = 1'b0;
    entry(1, exp_pc, 8'h20, 1'b0);
    entry(0, 16'h0300, 8'h24, 1'b0);
    fetch("R10 R11 both records served");

    // R4: held level enters once, with masking on
    do_reset();
    @(negedge clk); nmi_in = 1'b1;
    @(negedge clk);
    entry(1, exp_pc, 8'h24, 1'b0);
    fetch("R4 held level no retrigger");
    nmi_in = 1'b0;

    // sweep: source x status pattern x pc position
    for (int k = 0; k < 3; k++) begin
      for (int s = 0; s < 4; s++) begin
        logic [7:0]  v, st;
        logic [15:0] ret;
        do_reset();
        for (int n = 0; n < k * 4 + s + 1; n++) fetch("R2 sweep fetch");
        v = 8'h41 | (s[0] ? 8'h08 : 8'h00) | (s[1] ? 8'h82 : 8'h00)
            | ((k != 0 && s[1]) ? 8'h04 : 8'h00) | 8'h10;
        load_sr(v);
        st = (v & 8'hCF) | 8'h20 | ((k == 2) ? 8'h10 : 8'h00);
        ret = (k == 2) ? exp_pc + 16'd2 : exp_pc;
        if (k == 2) mem[exp_pc[11:0]] = 8'h00;
        if (k == 0) begin
          @(negedge clk); irq_in = 1'b1;
          @(negedge clk);
        end else if (k == 1) begin
          @(negedge clk); nmi_in = 1'b1;
          @(negedge clk); nmi_in = 1'b0;
        end
        entry(k, ret, st, s == 3);
        irq_in = 1'b0;
        mem[(ret[11:0] - 12'd2)] = 8'hEA;
        fetch("R11 sweep record cleared");
      end
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule